// File: doc/BRIEF.md
# Sleep Entry and Exit Sequencer

This block governs the low-power state of a synchronous memory's access logic. A raw sleep request arrives with no timing relation to the clock. The block synchronizes it and then steps through a fixed sequence: a two-cycle entry phase, a sleep phase, a two-cycle exit phase and a recovery interval whose length is set by a parameter. An access-block output covers the whole sequence, from the first entry cycle to the last recovery cycle. The access controller uses this output to stop every read and write.

At the start of entry, a one-cycle pulse tells the access controller to drop any accesses still pending. Such accesses are not valid and need not complete. Stored data is not disturbed.

The block also watches the chip-select and address-strobe activity. It raises a protocol-error flag when that activity appears while the device is entering sleep, leaving sleep or in recovery, because the selects and strobes must be idle in those phases.

Top module: `nap_sequencer`

## Requirements
- R1: While `rst` is high, and on the clock after it falls, all five outputs are low.
- R2: `sleep_pin` passes through a two-flop synchronizer. A rise that is stable before rising edge k makes `block_access` and `drop_pending` rise on edge k+2, provided the block is awake.
- R3: Entry lasts exactly two cycles. `sleep_active` rises two edges after `block_access` rises.
- R4: `drop_pending` is a single-cycle pulse that coincides with the first entry cycle.
- R5: Once started, entry always completes. If the request is withdrawn during entry, `sleep_active` is still high for at least one cycle, and exit then follows.
- R6: When the synchronized request is low while asleep, `sleep_active` falls on the next edge. Exit lasts two cycles, with only `block_access` high. `recov_busy` rises on the edge after exit ends.
- R7: `recov_busy` stays high for exactly `RECOVERY_CYCLES` cycles. `block_access` and `recov_busy` fall on the same edge.
- R8: `block_access` stays high without a gap from the first entry cycle to the last recovery cycle.
- R9: If `sel_active`, or either bit of `strobe_active`, is high in an entry, exit or recovery cycle, `proto_err` is high in the following cycle.
- R10: Select or strobe activity while awake or while asleep leaves `proto_err` low.
- R11: If the request is high again when recovery ends, the block is awake, with all outputs low, for exactly one cycle. A new entry, with its `drop_pending` pulse, begins on the next edge.
- R12: `sleep_active` and `recov_busy` are never high together, and each one implies `block_access`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sleep_pin | input | 1 | Raw asynchronous sleep request, active high |
| sel_active | input | 1 | High when the device is selected by its chip enables |
| strobe_active | input | 2 | Address strobe activity, one bit per strobe, active high |
| block_access | output | 1 | Suppress all reads and writes |
| sleep_active | output | 1 | Device is in the sleep state |
| recov_busy | output | 1 | Recovery interval in progress |
| drop_pending | output | 1 | One-cycle pulse: discard pending accesses |
| proto_err | output | 1 | Select or strobe seen in a phase where they must be idle |

## Verification
Two events can fall on the same edge. The first is the end of recovery. The second is a fresh sleep request that was raised again while recovery was still running. The bench provokes this by raising the pin in the first recovery cycle. It then expects the awake state for one cycle, which releases `block_access`, followed at once by a new entry pulse. A second overlap is a select or strobe that arrives exactly at a phase boundary, in the first entry cycle or the first recovery cycle. For that case, the scoreboard expects the error flag together with the phase outputs of the cycle that follows.

// File: rtl/nap_pkg.sv
package nap_pkg;
  typedef enum logic [2:0] {
    NS_AWAKE  = 3'd0,
    NS_ENTER  = 3'd1,
    NS_ASLEEP = 3'd2,
    NS_EXIT   = 3'd3,
    NS_RECOV  = 3'd4
  } nap_state_e;
endpackage

// File: rtl/nap_sync.sv
module nap_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= din;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], din};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/nap_fsm.sv
module nap_fsm
  import nap_pkg::*;
#(
  parameter int LATENCY         = 2,
  parameter int RECOVERY_CYCLES = 6
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       req,
  output nap_state_e state,
  output logic       block_q,
  output logic       sleep_q,
  output logic       recov_q,
  output logic       drop_q
);
  localparam int CMAX = (LATENCY > RECOVERY_CYCLES) ? LATENCY : RECOVERY_CYCLES;
  localparam int CW   = $clog2(CMAX + 1);
  localparam logic [CW-1:0] LAT_LOAD = CW'(LATENCY - 1);
  localparam logic [CW-1:0] REC_LOAD = CW'(RECOVERY_CYCLES - 1);

  nap_state_e       nxt;
  logic [CW-1:0]    cnt, cnt_nxt;
  logic             cnt_zero;

  assign cnt_zero = (cnt == '0);

  always_comb begin
    nxt     = state;
    cnt_nxt = cnt;
    unique case (state)
      NS_AWAKE: begin
        if (req) begin
          nxt     = NS_ENTER;
          cnt_nxt = LAT_LOAD;
        end
      end
      NS_ENTER: begin
        if (cnt_zero) nxt = NS_ASLEEP;
        else          cnt_nxt = cnt - 1'b1;
      end
      NS_ASLEEP: begin
        if (!req) begin
          nxt     = NS_EXIT;
          cnt_nxt = LAT_LOAD;
        end
      end
      NS_EXIT: begin
        if (cnt_zero) begin
          nxt     = NS_RECOV;
          cnt_nxt = REC_LOAD;
        end else begin
          cnt_nxt = cnt - 1'b1;
        end
      end
      NS_RECOV: begin
        if (cnt_zero) nxt = NS_AWAKE;
        else          cnt_nxt = cnt - 1'b1;
      end
      default: begin
        nxt     = NS_AWAKE;
        cnt_nxt = '0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= NS_AWAKE;
      cnt     <= '0;
      block_q <= 1'b0;
      sleep_q <= 1'b0;
      recov_q <= 1'b0;
      drop_q  <= 1'b0;
    end else begin
      state   <= nxt;
      cnt     <= cnt_nxt;
      block_q <= (nxt != NS_AWAKE);
      sleep_q <= (nxt == NS_ASLEEP);
      recov_q <= (nxt == NS_RECOV);
      drop_q  <= (state == NS_AWAKE) && (nxt == NS_ENTER);
    end
  end

  p_exclusive_r12: assert property (@(posedge clk) disable iff (rst)
    !(sleep_q && recov_q));
  p_cover_block_r12: assert property (@(posedge clk) disable iff (rst)
    (sleep_q || recov_q) |-> block_q);
  p_drop_single_r4: assert property (@(posedge clk) disable iff (rst)
    drop_q |=> !drop_q);
  p_drop_opens_block_r8: assert property (@(posedge clk) disable iff (rst)
    drop_q |-> (block_q && !$past(block_q)));
  p_entry_two_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(sleep_q) |-> $past(drop_q, 2));
  p_exit_two_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(recov_q) |-> (!$past(sleep_q) && !$past(sleep_q, 2) && $past(sleep_q, 3)));
  p_release_after_recov_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(block_q) |-> $past(recov_q));
endmodule

// File: rtl/nap_guard.sv
module nap_guard
  import nap_pkg::*;
#(
  parameter int STROBES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  nap_state_e         state,
  input  logic               sel,
  input  logic [STROBES-1:0] stb,
  output logic               err_q
);
  logic quiet_phase;
  logic activity;

  assign quiet_phase = (state == NS_ENTER) || (state == NS_EXIT) || (state == NS_RECOV);
  assign activity    = sel || (|stb);

  always_ff @(posedge clk) begin
    if (rst) err_q <= 1'b0;
    else     err_q <= quiet_phase && activity;
  end

  p_err_needs_activity_r9: assert property (@(posedge clk) disable iff (rst)
    err_q |-> ($past(sel) || $past(|stb)));
endmodule

// File: rtl/nap_sequencer.sv
module nap_sequencer
  import nap_pkg::*;
#(
  parameter int SYNC_STAGES     = 2,
  parameter int LATENCY         = 2,
  parameter int RECOVERY_CYCLES = 6,
  parameter int STROBES         = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sleep_pin,
  input  logic               sel_active,
  input  logic [STROBES-1:0] strobe_active,
  output logic               block_access,
  output logic               sleep_active,
  output logic               recov_busy,
  output logic               drop_pending,
  output logic               proto_err
);
  logic       req_sync;
  nap_state_e state;

  nap_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .din (sleep_pin),
    .q   (req_sync)
  );

  nap_fsm #(
    .LATENCY         (LATENCY),
    .RECOVERY_CYCLES (RECOVERY_CYCLES)
  ) u_fsm (
    .clk     (clk),
    .rst     (rst),
    .req     (req_sync),
    .state   (state),
    .block_q (block_access),
    .sleep_q (sleep_active),
    .recov_q (recov_busy),
    .drop_q  (drop_pending)
  );

  nap_guard #(.STROBES(STROBES)) u_guard (
    .clk   (clk),
    .rst   (rst),
    .state (state),
    .sel   (sel_active),
    .stb   (strobe_active),
    .err_q (proto_err)
  );

  p_err_in_quiet_phase_r9: assert property (@(posedge clk) disable iff (rst)
    proto_err |-> ($past(block_access) && !$past(sleep_active)));
  p_entry_follows_request_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(block_access) |-> $past(req_sync));
endmodule

// File: tb/test_nap_sequencer.sv
`timescale 1ns/1ps
module test_nap_sequencer;
  localparam int RC = 5;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       pin = 1'b0;
  logic       sel = 1'b0;
  logic [1:0] stb = 2'b00;
  logic       block_access, sleep_active, recov_busy, drop_pending, proto_err;

  nap_sequencer #(.RECOVERY_CYCLES(RC)) i_nap_sequencer (
    .clk           (clk),
    .rst           (rst),
    .sleep_pin     (pin),
    .sel_active    (sel),
    .strobe_active (stb),
    .block_access  (block_access),
    .sleep_active  (sleep_active),
    .recov_busy    (recov_busy),
    .drop_pending  (drop_pending),
    .proto_err     (proto_err)
  );

  always #2 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int  checks = 0;
  int  fails  = 0;
  bit  done   = 0;

  // bit order: [4] proto_err [3] drop_pending [2] recov_busy [1] sleep_active [0] block_access
  localparam logic [4:0] V_AWAKE  = 5'b00000;
  localparam logic [4:0] V_ENTER1 = 5'b01001;
  localparam logic [4:0] V_ENTER2 = 5'b00001;
  localparam logic [4:0] V_ASLEEP = 5'b00011;
  localparam logic [4:0] V_EXIT   = 5'b00001;
  localparam logic [4:0] V_RECOV  = 5'b00101;

  typedef struct {
    int         at;
    logic [4:0] v;
    string      tag;
  } exp_t;

  exp_t sb[$];

  function automatic logic [4:0] observed();
    return {proto_err, drop_pending, recov_busy, sleep_active, block_access};
  endfunction

  function automatic void push(int at, logic [4:0] v, string tag);
    exp_t e;
    int   i = 0;
    e.at = at; e.v = v; e.tag = tag;
    while (i < sb.size() && sb[i].at <= at) i++;
    sb.insert(i, e);
  endfunction

  // monitor: compares due scoreboard entries away from the active edge
  always @(negedge clk) begin
    exp_t e;
    while (sb.size() > 0 && sb[0].at <= cyc) begin
      e = sb.pop_front();
      checks++;
      if (e.at != cyc || observed() !== e.v) begin
        fails++;
        $display("FAIL %s cycle %0d: got %b expected %b", e.tag, e.at, observed(), e.v);
      end
    end
  end

  task automatic sleep_run(input int L, input int phase, input logic [2:0] pv,
                           input bit rereq, input bit cont, input int c0,
                           output int a_out);
    int c, d, ex, a, p, first, last;
    logic [4:0] v;
    string tag;
    if (cont) begin
      c = c0; first = c + 3;
    end else begin
      @(negedge clk);
      c = cyc; pin = 1'b1; first = c + 1;
    end
    d  = c + L;
    ex = (d + 3 > c + 6) ? d + 3 : c + 6;
    a  = ex + 2 + RC;
    case (phase)
      1: p = c + 3;
      2: p = c + 5;
      3: p = ex;
      4: p = ex + 2;
      5: p = a;
      default: p = -10;
    endcase
    last = rereq ? a : a + 1;
    for (int t = first; t <= last; t++) begin
      if (t <= c + 2)       begin v = V_AWAKE;  tag = "R2"; end
      else if (t == c + 3)  begin v = V_ENTER1; tag = "R2 R4 R8"; end
      else if (t == c + 4)  begin v = V_ENTER2; tag = "R3 R4"; end
      else if (t < ex)      begin v = V_ASLEEP; tag = (L <= 3) ? "R5" : "R3 R12"; end
      else if (t < ex + 2)  begin v = V_EXIT;   tag = "R6"; end
      else if (t < a)       begin v = V_RECOV;  tag = "R7 R12"; end
      else                  begin v = V_AWAKE;  tag = rereq ? "R11" : "R7"; end
      if (t == p + 1) begin
        if (phase == 1 || phase == 3 || phase == 4) begin v[4] = 1'b1; tag = "R9"; end
        else tag = "R10";
      end
      push(t, v, tag);
    end
    while (cyc < last) begin
      if (cyc >= d) pin = 1'b0;
      if (rereq && cyc >= ex + 2) pin = 1'b1;
      sel = (cyc == p) ? pv[2] : 1'b0;
      stb = (cyc == p) ? pv[1:0] : 2'b00;
      @(negedge clk);
    end
    sel = 1'b0; stb = 2'b00;
    a_out = a;
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog: run did not finish, got hang expected completion");
    summary();
  end

  initial begin
    int a, c;
    repeat (3) @(negedge clk);
    checks++;
    if (observed() !== V_AWAKE) begin
      fails++;
      $display("FAIL R1 in reset: got %b expected %b", observed(), V_AWAKE);
    end
    rst = 1'b0;
    c = cyc;
    sel = 1'b1; stb = 2'b11;
    for (int t = c + 1; t <= c + 4; t++) push(t, V_AWAKE, "R1 R10");
    repeat (4) @(negedge clk);
    sel = 1'b0; stb = 2'b00;
    repeat (2) @(negedge clk);

    sleep_run(10, 0, 3'b000, 0, 0, 0, a);   // plain sequence
    sleep_run(3,  0, 3'b000, 0, 0, 0, a);   // R5 release during entry
    sleep_run(8,  1, 3'b100, 0, 0, 0, a);   // R9 select in entry
    sleep_run(8,  2, 3'b111, 0, 0, 0, a);   // R10 activity while asleep
    sleep_run(8,  3, 3'b001, 0, 0, 0, a);   // R9 strobe in exit
    sleep_run(8,  4, 3'b010, 0, 0, 0, a);   // R9 strobe in first recovery cycle
    sleep_run(8,  5, 3'b100, 0, 0, 0, a);   // R10 select once awake again
    sleep_run(9,  0, 3'b000, 1, 0, 0, a);   // R11 request returns during recovery
    sleep_run(6,  1, 3'b010, 0, 1, a - 2, a); // R11 continuation with entry-edge error R9
    repeat (4) @(negedge clk);
    if (sb.size() != 0) begin
      fails++;
      $display("FAIL scoreboard: got %0d pending expected 0", sb.size());
    end
    summary();
  end
endmodule